// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic-logic unit of a small multi-cycle processor. It is purely combinational. It has two operand-source multiplexers in front of it, and they are driven by the control sequencer. The first operand is either the program counter or the first register-file read port. The second operand is one of three values: the second register-file read port, the constant one, or a 7-bit immediate that is sign-extended to 16 bits. Because the constant one can be selected, the same adder that executes program instructions also forms the next program counter.

A three-bit operation code selects one of five functions: add, subtract, bitwise AND, bitwise OR, or a signed set-less-than. Two status outputs come with the 16-bit result. The negative flag is a copy of the result's top bit. The zero flag is high when every result bit is clear.

Top module: `alu16_unit`

## Requirements
- R1: With op_code 3'b000 the result is (A + B) modulo 2^16.
- R2: With op_code 3'b001 the result is (A - B) modulo 2^16.
- R3: With op_code 3'b010 the result is the bitwise AND of A and B.
- R4: With op_code 3'b011 the result is the bitwise OR of A and B.
- R5: With op_code 3'b100 the result is 16'd1 when A is less than B as signed two's-complement values, and 16'd0 otherwise.
- R6: Any op_code from 3'b101 to 3'b111 gives a result of zero, whatever the operands are.
- R7: When use_pc is 1, A is pc_in. When use_pc is 0, A is reg_a.
- R8: b_src selects B. 2'b00 selects reg_b. 2'b01 selects the constant 1. 2'b10 selects imm7 sign-extended from its bit 6. 2'b11 is reserved and selects reg_b.
- R9: flag_n equals bit 15 of the result.
- R10: flag_z is 1 exactly when all 16 result bits are zero.
- R11: The outputs follow any input change within the same clock period. The block holds no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_in | input | 16 | Program counter value, a candidate for A |
| reg_a | input | 16 | First register-file read data, a candidate for A |
| reg_b | input | 16 | Second register-file read data, a candidate for B |
| imm7 | input | 7 | Immediate field, sign-extended when chosen as B |
| use_pc | input | 1 | 1 selects pc_in as A, 0 selects reg_a |
| b_src | input | 2 | Source select for B |
| op_code | input | 3 | Function select |
| result | output | 16 | Function result |
| flag_n | output | 1 | Negative status, the top bit of the result |
| flag_z | output | 1 | Zero status, set when the result is all zeros |

## Verification
Every result and both flags are due in the same clock period as the input change that causes them, because no register lies on any path through the block. The bench drives a new operand set just after each rising edge. It compares result, flag_n and flag_z against a behavioural integer model at the following falling edge, half a period later, so every check observes a settled value for the cycle under test. Directed vectors cover each source select, the program-counter increment, signed comparison across the sign boundary and the unused operation codes. Pseudo-random vectors then sweep all selects and codes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  parameter int unsigned DATA_W = 16;
  parameter int unsigned IMM_W  = 7;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_SLT = 3'b100
  } alu_op_e;

  typedef enum logic [SEL_W-1:0] {
    BSRC_REG  = 2'b00,
    BSRC_ONE  = 2'b01,
    BSRC_IMM  = 2'b10,
    BSRC_RSVD = 2'b11
  } b_src_e;

  typedef logic [DATA_W-1:0] word_t;

  // Sign-extend the immediate field up to the data width.
  function automatic word_t sext_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  // Signed less-than computed from the subtraction and its overflow.
  function automatic logic signed_lt(input word_t a, input word_t b);
    word_t d;
    logic  ovf;
    d   = a - b;
    ovf = (a[DATA_W-1] != b[DATA_W-1]) && (d[DATA_W-1] != a[DATA_W-1]);
    return d[DATA_W-1] ^ ovf;
  endfunction

  function automatic word_t eval_op(input logic [OP_W-1:0] op,
                                    input word_t a, input word_t b);
    word_t r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_SLT:  r = {{(DATA_W-1){1'b0}}, signed_lt(a, b)};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu16_opsel.sv
module alu16_opsel
  import alu16_pkg::*;
(
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              a_pc,
  input  logic [SEL_W-1:0]  b_sel,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  assign a_out = a_pc ? pc_val : rf_a;

  always_comb begin
    case (b_sel)
      BSRC_ONE: b_out = ONE;
      BSRC_IMM: b_out = sext_imm(imm);
      default:  b_out = rf_b;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  assign y = eval_op(op, a, b);

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
(
  input  logic [DATA_W-1:0] y,
  output logic              neg,
  output logic              zro
);

  assign neg = y[DATA_W-1];
  assign zro = ~|y;

endmodule

// File: rtl/alu16_unit.sv
module alu16_unit
  import alu16_pkg::*;
(
  input  logic [15:0] pc_in,
  input  logic [15:0] reg_a,
  input  logic [15:0] reg_b,
  input  logic [6:0]  imm7,
  input  logic        use_pc,
  input  logic [1:0]  b_src,
  input  logic [2:0]  op_code,
  output logic [15:0] result,
  output logic        flag_n,
  output logic        flag_z
);

  // Named internal nets, brought out for the checker.
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] core_y;

  alu16_opsel u_sel (
    .pc_val (pc_in),
    .rf_a   (reg_a),
    .rf_b   (reg_b),
    .imm    (imm7),
    .a_pc   (use_pc),
    .b_sel  (b_src),
    .a_out  (opnd_a),
    .b_out  (opnd_b)
  );

  alu16_core u_core (
    .op (op_code),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (core_y)
  );

  alu16_flags u_flags (
    .y   (core_y),
    .neg (flag_n),
    .zro (flag_z)
  );

  assign result = core_y;

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker (
  input logic [15:0] pc_in,
  input logic [15:0] reg_b,
  input logic [6:0]  imm7,
  input logic        use_pc,
  input logic [1:0]  b_src,
  input logic [2:0]  op_code,
  input logic [15:0] opnd_a,
  input logic [15:0] opnd_b,
  input logic [15:0] result,
  input logic        flag_n,
  input logic        flag_z
);

  always_comb begin
    // R1 with R7 and R8: next program counter through the adder
    if (use_pc && b_src == 2'b01 && op_code == 3'b000)
      p_pc_incr_r1: assert (result == pc_in + 16'd1);
    // R5: comparison yields only 0 or 1, and never sets N
    if (op_code == 3'b100) begin
      p_slt_bool_r5: assert (result[15:1] == 15'd0);
      p_slt_pos_r9:  assert (!flag_n);
    end
    // R6: unused codes give zero with Z set
    if (op_code > 3'b100)
      p_undef_zero_r6: assert (result == 16'd0 && flag_z);
    // R3: AND never sets a bit clear in A
    if (op_code == 3'b010)
      p_and_subset_r3: assert ((result & ~opnd_a) == 16'd0);
    // R4 with R9: OR with a negative operand is negative
    if (op_code == 3'b011 && (opnd_a[15] || opnd_b[15]))
      p_or_neg_r9: assert (flag_n);
    // R10: equal operands subtract to zero
    if (op_code == 3'b001 && opnd_a == opnd_b)
      p_sub_zero_r10: assert (flag_z && result == 16'd0);
    // R8: immediate source is sign-extended
    if (b_src == 2'b10)
      p_imm_ext_r8: assert (opnd_b[15:6] == {10{imm7[6]}});
    // R8: reserved select behaves as register B
    if (b_src == 2'b11)
      p_rsvd_regb_r8: assert (opnd_b == reg_b);
  end

endmodule

bind alu16_unit alu16_checker chk_i (
  .pc_in   (pc_in),
  .reg_b   (reg_b),
  .imm7    (imm7),
  .use_pc  (use_pc),
  .b_src   (b_src),
  .op_code (op_code),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .result  (result),
  .flag_n  (flag_n),
  .flag_z  (flag_z)
);

// File: tb/alu16_unit_tb_top.sv
module alu16_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc_in = '0, reg_a = '0, reg_b = '0;
  logic [6:0]  imm7 = '0;
  logic        use_pc = 1'b0;
  logic [1:0]  b_src = '0;
  logic [2:0]  op_code = '0;
  logic [15:0] result;
  logic        flag_n, flag_z;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu16_unit dut_i (
    .pc_in(pc_in), .reg_a(reg_a), .reg_b(reg_b), .imm7(imm7),
    .use_pc(use_pc), .b_src(b_src), .op_code(op_code),
    .result(result), .flag_n(flag_n), .flag_z(flag_z)
  );

  // Behavioural reference model on plain integers.
  function automatic int to_signed16(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int model_b(int sel, int rb, int im);
    if (sel == 1) return 1;
    if (sel == 2) return (im >= 64) ? (im - 128) & 65535 : im;
    return rb;
  endfunction

  function automatic int model_res(int op, int a, int b);
    case (op)
      0: return (a + b) % 65536;
      1: return (a - b + 65536) % 65536;
      2: return a & b;
      3: return a | b;
      4: return (to_signed16(a) < to_signed16(b)) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0d bsel=%0d pc=%0b)",
               req, act, exp, op_code, b_src, use_pc);
    end
  endtask

  // Drive after a rising edge, compare at the next falling edge.
  task automatic apply(int op, bit pcsel, int sel, int pcv, int ra, int rb,
                       int im, string req);
    int a, b, r;
    @(posedge clk);
    op_code = 3'(op); use_pc = pcsel; b_src = 2'(sel);
    pc_in = 16'(pcv); reg_a = 16'(ra); reg_b = 16'(rb); imm7 = 7'(im);
    @(negedge clk);
    a = pcsel ? pcv : ra;
    b = model_b(sel, rb, im);
    r = model_res(op, a, b);
    check({req, "/", op_tag(op)}, int'(result), r);
    check("R9", int'(flag_n), (r >= 32768) ? 1 : 0);
    check("R10", int'(flag_z), (r == 0) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle result", int'(result), 0);
    check("R10 idle zero", int'(flag_z), 1);

    apply(0, 1, 1, 16'h00ff, 16'h1234, 16'h5555, 0, "R1 pc+1");
    apply(0, 1, 1, 16'hffff, 0, 0, 0, "R1 pc wrap");
    apply(0, 0, 0, 16'h7777, 16'h7fff, 16'h0001, 0, "R7 rega");
    apply(1, 0, 0, 0, 16'h0003, 16'h0005, 0, "R2 borrow");
    apply(1, 1, 0, 16'h4444, 0, 16'h4444, 0, "R7 pc equal");
    apply(2, 0, 0, 0, 16'hf0f0, 16'h3c3c, 0, "R3");
    apply(3, 0, 0, 0, 16'h0f00, 16'h8001, 0, "R4");
    apply(4, 0, 0, 0, 16'hffff, 16'h0001, 0, "R5 neg<pos");
    apply(4, 0, 0, 0, 16'h0001, 16'hffff, 0, "R5 pos>neg");
    apply(4, 0, 0, 0, 16'h8000, 16'h7fff, 0, "R5 extremes");
    apply(4, 0, 0, 0, 16'h2222, 16'h2222, 0, "R5 equal");
    apply(0, 0, 2, 0, 16'h0010, 16'hdead, 7'h7f, "R8 imm -1");
    apply(0, 0, 2, 0, 16'h0010, 16'hdead, 7'h40, "R8 imm -64");
    apply(0, 0, 2, 0, 16'h0010, 16'hdead, 7'h3f, "R8 imm +63");
    apply(0, 0, 3, 0, 16'h0100, 16'h0023, 7'h7f, "R8 reserved");
    apply(0, 0, 1, 0, 16'h0100, 16'hbeef, 0, "R8 one");
    for (int k = 5; k < 8; k++)
      apply(k, 0, 0, 0, 16'hffff, 16'h8001, 0, "R6 unused");

    // R11: back-to-back changes, each checked in its own period
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 3),
            $urandom_range(0, 65535), $urandom_range(0, 65535),
            $urandom_range(0, 65535), $urandom_range(0, 127), "R11 rand");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule